// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block is a synthesizable behavioural model of a byte-wide memory that can be written only once per bit. Its control pins (active-low chip select, output gate and program strobe) work as they would on a stand-alone part, but they are sampled on a system clock. Two digital flags replace the analog levels. One reports that the programming supply is present. The other reports that a high voltage sits on address line nine. From the sampled pins the block decodes eight operating modes: read, output disable, standby, program, program verify, program inhibit, identify, and a guarded no-op.

The storage starts fully erased, with every bit at one. A program cycle can only clear bits, because the new byte is combined with the old contents by AND. The identify mode returns a fixed maker byte or a fixed part byte, picked by address bit 0. The block has no real tri-state. A registered drive-enable output stands in for it, and the data bus is forced to zero whenever that enable is low.

Top module: `otp_mode_ctrl`

## Requirements
- R1: After reset, drive_en is 0 and dout is 00h, and every location reads back as FFh.
- R2: With ce_n=0, oe_n=0, vpp_on=0 and a9_hv=0, the byte stored at addr is driven: drive_en=1 and dout equals the stored byte.
- R3: With ce_n=1 and vpp_on=0, the block is in standby: drive_en=0 and dout=00h whatever oe_n, pgm_n and a9_hv are.
- R4: With ce_n=0 and oe_n=1, and no program strobe under supply, the block is in output disable: drive_en=0, dout=00h, and nothing is written.
- R5: With ce_n=0, oe_n=1, pgm_n=0 and vpp_on=1, the location at addr is written with all 8 bits in parallel, and the outputs are not driven during the cycle.
- R6: A write stores the old byte AND din, so a later program cycle can never turn a 0 bit back into 1.
- R7: With ce_n=0, oe_n=0, pgm_n=1 and vpp_on=1, program verify drives the stored byte: drive_en=1 and dout equals the stored byte.
- R8: With vpp_on=1 and ce_n=1, program is inhibited: no location changes, and drive_en=0 whatever oe_n and pgm_n are.
- R9: With ce_n=0, oe_n=0, vpp_on=0 and a9_hv=1, dout is C2h when addr[0]=0 and CAh when addr[0]=1, with drive_en=1. All other address bits are ignored, and nothing is written.
- R10: drive_en and dout are registered. The values of a pin state applied before a rising clk edge appear just after that edge and not before it, and dout is 00h whenever drive_en is 0.
- R11: With ce_n=0, oe_n=0, pgm_n=0 and vpp_on=1, nothing is written and the outputs are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Active-low reset; erases the array and stops the drive |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage present on address line nine (identify request) |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to be programmed |
| dout | output | 8 | Byte driven out; 00h when not driving |
| drive_en | output | 1 | Registered output-drive enable (models tri-state) |

## Verification
Every output follows the pins with exactly one register. The bench therefore changes the pins on the falling clock edge and samples drive_en and dout one time unit after the next rising edge. A write made at one edge is seen through a read issued in the following cycle, so each write sweep is followed by a separate read sweep. To show that the outputs do not move early, the bench also samples just before the edge and checks that they still hold the previous mode's values.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_INHIBIT,
        MODE_OUTDIS,
        MODE_PROGRAM,
        MODE_VERIFY,
        MODE_READ,
        MODE_IDENT,
        MODE_GUARD
    } otp_mode_e;

    typedef struct packed {
        logic              drive;
        logic [BYTE_W-1:0] data;
    } otp_out_t;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    input  logic      vpp_on,
    input  logic      a9_hv,
    output otp_mode_e mode
);
    always_comb begin
        if (ce_n) begin
            // deselected: supply present means inhibit, otherwise standby
            mode = vpp_on ? MODE_INHIBIT : MODE_STANDBY;
        end else if (oe_n) begin
            mode = (vpp_on && !pgm_n) ? MODE_PROGRAM : MODE_OUTDIS;
        end else if (vpp_on) begin
            // output gate open under supply: verify only with strobe idle
            mode = pgm_n ? MODE_VERIFY : MODE_GUARD;
        end else begin
            mode = a9_hv ? MODE_IDENT : MODE_READ;
        end
    end
endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cell_q [DEPTH];
    logic [BYTE_W-1:0] cell_d [DEPTH];

    // one clear-only update path per location
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        always_comb begin
            cell_d[gi] = cell_q[gi];
            if (wr_en && (addr == ADDR_W'(gi))) begin
                cell_d[gi] = cell_q[gi] & wr_byte;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[gi] <= '1;
            end else begin
                cell_q[gi] <= cell_d[gi];
            end
        end
    end

    assign rd_byte = cell_q[addr];
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [7:0]  MFR_CODE = 8'hC2,
    parameter logic [7:0]  DEV_CODE = 8'hCA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              drive_en
);
    otp_mode_e         mode;
    logic [BYTE_W-1:0] stored;
    logic              wr_en;
    otp_out_t          out_d;
    otp_out_t          out_q;

    otp_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    assign wr_en = (mode == MODE_PROGRAM);

    otp_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_byte (din),
        .rd_byte (stored)
    );

    always_comb begin
        out_d = '0;
        unique case (mode)
            MODE_READ, MODE_VERIFY: begin
                out_d.drive = 1'b1;
                out_d.data  = stored;
            end
            MODE_IDENT: begin
                out_d.drive = 1'b1;
                out_d.data  = addr[0] ? DEV_CODE : MFR_CODE;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign drive_en = out_q.drive;
    assign dout     = out_q.data;
endmodule

// File: rtl/otp_mode_chk.sv
module otp_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       pgm_n,
    input logic       vpp_on,
    input logic       a9_hv,
    input logic       addr_lsb,
    input logic [7:0] dout,
    input logic       drive_en
);
    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_on) |=> (!drive_en && dout == 8'h00));

    // R8
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_on) |=> !drive_en);

    // R4
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !drive_en);

    // R5
    program_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !pgm_n && vpp_on) |=> (dout == 8'h00));

    // R9
    ident_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_on && a9_hv && !addr_lsb) |=> (drive_en && dout == 8'hC2));

    // R9
    ident_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_on && a9_hv && addr_lsb) |=> (drive_en && dout == 8'hCA));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (dout == 8'h00));

    // R11
    guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !pgm_n && vpp_on) |=> !drive_en);
endmodule

bind otp_mode_ctrl otp_mode_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_on   (vpp_on),
    .a9_hv    (a9_hv),
    .addr_lsb (addr[0]),
    .dout     (dout),
    .drive_en (drive_en)
);

// File: tb/otp_mode_ctrl_test.sv
`timescale 1ns/1ps
module otp_mode_ctrl_test;
    localparam int    CLK_PERIOD = 10;
    localparam int    AW         = 6;
    localparam int    NLOC       = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          drive_en;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [7:0] model [NLOC];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_mode_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_on(vpp_on), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .drive_en(drive_en)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply pins on the falling edge, sample just after the next rising edge
    task automatic cyc(input logic c, input logic o, input logic p, input logic v,
                       input logic h, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; a9_hv = h; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), 8'h00);
            chk(req, {drive_en, dout}, {1'b1, model[a]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < NLOC; a++) model[a] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 chk("R1", {drive_en, dout}, 9'h000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", {drive_en, dout}, 9'h000);

        // R1: erased contents
        read_all("R1");

        // R10: outputs hold until the edge, then follow
        @(negedge clk); ce_n = 1'b1;
        #1 chk("R10", {8'h00, drive_en}, 9'h001);
        @(posedge clk); #1;
        chk("R10", {drive_en, dout}, 9'h000);

        // R5: first program pass, outputs quiet
        for (int a = 0; a < NLOC; a++) begin
            logic [7:0] pat = 8'(a * 37) ^ 8'h5A;
            model[a] = model[a] & pat;
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), pat);
            chk("R5", {drive_en, dout}, 9'h000);
        end
        read_all("R2");

        // R6: second pass tries to set bits back
        for (int a = 0; a < NLOC; a++) begin
            logic [7:0] pat = 8'({a[5:0], 2'b11}) ^ 8'hF0;
            model[a] = model[a] & pat;
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), pat);
        end
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), 8'hFF);
        end
        // R7: verify mode shows the cleared-only contents
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00);
            chk("R6/R7", {drive_en, dout}, {1'b1, model[a]});
        end

        // R8: inhibit blocks writes
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b1, a[0], 1'b0, 1'b1, 1'b0, AW'(a), 8'h00);
            chk("R8", {8'h00, drive_en}, 9'h000);
        end
        read_all("R8");

        // R11: strobe with output gate open under supply
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(a), 8'h00);
            chk("R11", {drive_en, dout}, 9'h000);
        end
        read_all("R11");

        // R3 and R4: all remaining control combinations
        for (int k = 0; k < 8; k++) begin
            cyc(1'b1, k[0], k[1], 1'b0, k[2], AW'(k), 8'h00);
            chk("R3", {drive_en, dout}, 9'h000);
            cyc(1'b0, 1'b1, k[1], 1'b0, k[2], AW'(k), 8'h00);
            chk("R4", {drive_en, dout}, 9'h000);
        end
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd5, 8'h00);
        chk("R4", {drive_en, dout}, 9'h000);
        read_all("R4");

        // R9: identify over every address, din varied
        for (int a = 0; a < NLOC; a++) begin
            cyc(1'b0, 1'b0, a[1], 1'b0, 1'b1, AW'(a), 8'(a));
            chk("R9", {drive_en, dout}, {1'b1, (a[0] ? 8'hCA : 8'hC2)});
        end
        read_all("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule